// File: doc/BRIEF.md
# Channel-Gain Scan Queue Sequencer

This block holds a programmable list of converter settings, one entry per slot, where each entry names a multiplexer channel and a gain code. A host fills the list in three steps. It selects a slot through an index register, writes the entry byte through an entry register, and sets the list size through a length register. When an acquisition runs, the block presents the setting of the current slot to the converter front end. It steps to the next slot each time the front end accepts a conversion, and it returns to slot 0 after the last slot of the list.

The block also checks the programmed list all the time. A list of one entry may use any channel. A longer list must have an even number of entries, and the low bit of each entry's channel must match the low bit of its slot number. When a list breaks either rule, the block raises an error flag and does not start an acquisition. The output side uses a valid/ready handshake. `out_valid` is high for the whole acquisition. The presented entry stays unchanged until the front end raises `conv_ready`, which plays the part of a conversion strobe. The front end applies back-pressure by keeping `conv_ready` low, and the block then stays on the same slot for as long as needed.

Top module: `scanq_seq`

## Requirements
- R1: After reset the block is idle (`out_valid` = 0), `list_error` = 0, the list length is 1, and every slot holds channel 0 with gain code 0.
- R2: A host write with `host_wr_sel` = 0 sets the slot index. A write with `host_wr_sel` = 1 stores the entry byte into the selected slot. In that byte, bits 2:0 are the channel and bits 7:4 are the gain code. During an acquisition the slot appears on `out_chan` and `out_gain`, and `out_unipolar` equals gain bit 2 (byte bit 6).
- R3: A host write with `host_wr_sel` = 2 sets the list length to the written value plus 1, so the length runs from 1 to 256. A write with `host_wr_sel` = 3 has no effect.
- R4: `out_valid` is high exactly while an acquisition runs. While `conv_ready` is low, the presented slot and its fields stay unchanged.
- R5: Each cycle in which `out_valid` and `conv_ready` are both high moves the slot to the next one. After the last slot, the next slot is 0. `out_last` is high while the last slot is presented.
- R6: A start request that is accepted begins the acquisition at slot 0 on the next cycle. A start request made while an acquisition is already running is ignored.
- R7: If the length is 2 or more and any slot below the length has a channel whose low bit differs from the low bit of the slot number, `list_error` is high. Slots at or above the length do not count.
- R8: If the length is odd and 3 or more, `list_error` is high. A length of 1 never raises `list_error`, whatever its channel.
- R9: A start request made while `list_error` is high is refused, and `out_valid` stays low.
- R10: Host writes to any register are ignored while an acquisition runs.
- R11: `acq_stop` ends the acquisition on the next cycle. If `acq_start` and `acq_stop` arrive together, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 2 | Register select: 0 index, 1 entry, 2 length |
| host_wr_data | input | 8 | Host write data |
| acq_start | input | 1 | Request to begin an acquisition |
| acq_stop | input | 1 | Request to end the acquisition |
| conv_ready | input | 1 | Front end accepts the presented setting |
| out_valid | output | 1 | Acquisition running, setting valid |
| out_chan | output | 3 | Multiplexer channel of the current slot |
| out_gain | output | 4 | Gain code of the current slot |
| out_unipolar | output | 1 | Unipolar range selected |
| out_index | output | 8 | Current slot number |
| out_last | output | 1 | Current slot is the final one of the list |
| list_error | output | 1 | Programmed list breaks a parity rule |

## Verification
Every result appears one clock edge after the stimulus that causes it. A host write changes `list_error` after one edge. An accepted start raises `out_valid` at slot 0 after one edge. A handshake moves the slot after one edge, and a stop drops `out_valid` after one edge. The bench drives its inputs on the falling edge. It updates its reference model on the same rising edge at which the design registers those inputs, and it compares every output on the falling edge that follows. It therefore always samples one full edge after the stimulus and never at the edge itself.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  localparam int CHAN_W = 3;
  localparam int GAIN_W = 4;
  localparam int HOST_W = 8;

  typedef enum logic [1:0] {
    HSEL_INDEX  = 2'd0,
    HSEL_ENTRY  = 2'd1,
    HSEL_LENGTH = 2'd2
  } hsel_e;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [CHAN_W-1:0] chan;
  } entry_t;

  function automatic entry_t unpack_byte(input logic [HOST_W-1:0] b);
    entry_t e;
    e.gain = b[7:4];
    e.chan = b[2:0];
    return e;
  endfunction
endpackage

// File: rtl/scanq_store.sv
module scanq_store
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output entry_t           rd_entry
);
  entry_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (wr_en) begin
      slots[wr_idx] <= wr_entry;
    end
  end

  assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/scanq_rules.sv
module scanq_rules #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_chan_lsb,
  input  logic [IDX_W-1:0] len_m1,
  output logic             list_error
);
  logic [DEPTH-1:0] mismatch;
  logic [DEPTH-1:0] in_list;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic SLOT_LSB = 1'(g % 2);
    always_ff @(posedge clk) begin
      if (!rst_n) mismatch[g] <= SLOT_LSB;
      else if (wr_en && wr_idx == IDX_W'(g)) mismatch[g] <= wr_chan_lsb ^ SLOT_LSB;
    end
    assign in_list[g] = (IDX_W'(g) <= len_m1);
  end

  logic multi;
  logic odd_len;
  assign multi      = (len_m1 != '0);
  assign odd_len    = ~len_m1[0];
  assign list_error = multi && (odd_len || |(mismatch & in_list));
endmodule

// File: rtl/scanq_walker.sv
module scanq_walker #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic             stop,
  input  logic             ready,
  input  logic [IDX_W-1:0] len_m1,
  output logic             running,
  output logic [IDX_W-1:0] ptr,
  output logic             at_last
);
  assign at_last = (ptr == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      ptr     <= '0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (start_go) begin
      running <= 1'b1;
      ptr     <= '0;
    end else if (running && ready) begin
      ptr <= at_last ? '0 : ptr + IDX_W'(1);
    end
  end
endmodule

// File: rtl/scanq_seq.sv
module scanq_seq
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [1:0]        host_wr_sel,
  input  logic [HOST_W-1:0] host_wr_data,
  input  logic              acq_start,
  input  logic              acq_stop,
  input  logic              conv_ready,
  output logic              out_valid,
  output logic [CHAN_W-1:0] out_chan,
  output logic [GAIN_W-1:0] out_gain,
  output logic              out_unipolar,
  output logic [IDX_W-1:0]  out_index,
  output logic              out_last,
  output logic              list_error
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] len_m1_q;
  logic             running;
  logic             at_last;
  logic             host_ok;
  logic             entry_we;
  entry_t           wr_entry;
  entry_t           rd_entry;

  assign host_ok  = host_wr_en && !running;
  assign entry_we = host_ok && (host_wr_sel == HSEL_ENTRY);
  assign wr_entry = unpack_byte(host_wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      len_m1_q <= '0;
    end else if (host_ok) begin
      if (host_wr_sel == HSEL_INDEX)  idx_q    <= IDX_W'(host_wr_data);
      if (host_wr_sel == HSEL_LENGTH) len_m1_q <= IDX_W'(host_wr_data);
    end
  end

  scanq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(entry_we), .wr_idx(idx_q),
    .wr_entry(wr_entry), .rd_idx(out_index), .rd_entry(rd_entry)
  );

  scanq_rules #(.DEPTH(DEPTH)) rules_i (
    .clk(clk), .rst_n(rst_n), .wr_en(entry_we), .wr_idx(idx_q),
    .wr_chan_lsb(wr_entry.chan[0]), .len_m1(len_m1_q), .list_error(list_error)
  );

  scanq_walker #(.DEPTH(DEPTH)) walker_i (
    .clk(clk), .rst_n(rst_n),
    .start_go(acq_start && !running && !list_error),
    .stop(acq_stop), .ready(conv_ready), .len_m1(len_m1_q),
    .running(running), .ptr(out_index), .at_last(at_last)
  );

  assign out_valid    = running;
  assign out_chan     = rd_entry.chan;
  assign out_gain     = rd_entry.gain;
  assign out_unipolar = rd_entry.gain[2];
  assign out_last     = running && at_last;
endmodule

// File: rtl/scanq_seq_chk.sv
module scanq_seq_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_start,
  input logic             acq_stop,
  input logic             conv_ready,
  input logic             out_valid,
  input logic [2:0]       out_chan,
  input logic [3:0]       out_gain,
  input logic [IDX_W-1:0] out_index,
  input logic             out_last,
  input logic             list_error
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !conv_ready && !acq_stop) |=>
      (out_valid && $stable(out_index) && $stable(out_chan) && $stable(out_gain)));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && conv_ready && out_last && !acq_stop) |=> (out_index == '0));

  // R6
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && acq_start && !list_error && !acq_stop) |=> (out_valid && out_index == '0));

  // R9
  refuse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && list_error) |=> !out_valid);

  // R10
  frozen_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(list_error));

  // R11
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_stop |=> !out_valid);

  // R5
  last_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind scanq_seq scanq_seq_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .acq_stop(acq_stop),
  .conv_ready(conv_ready), .out_valid(out_valid), .out_chan(out_chan),
  .out_gain(out_gain), .out_index(out_index), .out_last(out_last),
  .list_error(list_error)
);

// File: tb/scanq_seq_tb_top.sv
module scanq_seq_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       host_wr_en = 1'b0;
  logic [1:0] host_wr_sel = 2'd0;
  logic [7:0] host_wr_data = 8'd0;
  logic       acq_start = 1'b0, acq_stop = 1'b0, conv_ready = 1'b0;
  logic       out_valid, out_unipolar, out_last, list_error;
  logic [2:0] out_chan;
  logic [3:0] out_gain;
  logic [7:0] out_index;

  scanq_seq dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] mm [256];
  int m_idx = 0, m_lenm1 = 0, m_ptr = 0;
  bit m_run = 0;

  function automatic bit m_err();
    if (m_lenm1 == 0) return 1'b0;
    if (m_lenm1 % 2 == 0) return 1'b1;
    for (int i = 0; i <= m_lenm1; i++) if (mm[i][0] != i[0]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    bit err_old, run_old;
    @(posedge clk);
    err_old = m_err();
    run_old = m_run;
    if (!run_old && host_wr_en) begin
      case (host_wr_sel)
        2'd0: m_idx = host_wr_data;
        2'd1: mm[m_idx] = host_wr_data & 8'hF7;
        2'd2: m_lenm1 = host_wr_data;
        default: ;
      endcase
    end
    if (acq_stop) m_run = 0;
    else if (acq_start && !run_old && !err_old) begin m_run = 1; m_ptr = 0; end
    else if (run_old && conv_ready) m_ptr = (m_ptr == m_lenm1) ? 0 : m_ptr + 1;
    @(negedge clk);
    chk("R4 valid", out_valid, m_run);
    chk("R7/R8 list_error", list_error, m_err());
    if (m_run) begin
      chk("R5 index", out_index, m_ptr);
      chk("R5 last", out_last, m_ptr == m_lenm1);
      chk("R2 chan", out_chan, mm[m_ptr][2:0]);
      chk("R2 gain", out_gain, mm[m_ptr][7:4]);
      chk("R2 unipolar", out_unipolar, mm[m_ptr][6]);
    end
  endtask

  task automatic hw(logic [1:0] s, logic [7:0] d);
    host_wr_en = 1; host_wr_sel = s; host_wr_data = d;
    tick();
    host_wr_en = 0;
  endtask

  task automatic put(int i, logic [7:0] b);
    hw(2'd0, 8'(i));
    hw(2'd1, b);
  endtask

  task automatic start();
    acq_start = 1; tick(); acq_start = 0;
  endtask

  task automatic stop();
    acq_stop = 1; tick(); acq_stop = 0;
  endtask

  task automatic conv(int n, int pct);
    for (int k = 0; k < n; k++) begin
      conv_ready = ($urandom % 100) < pct;
      tick();
    end
    conv_ready = 0;
  endtask

  function automatic logic [7:0] legal_byte(int i);
    logic [7:0] b;
    b = 8'($urandom);
    b[0] = i[0];
    return b;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 run did not finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mm[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 valid", out_valid, 0);
    chk("R1 list_error", list_error, 0);
    start();
    chk("R1 length one", out_last, 1);
    chk("R1 chan", out_chan, 0);
    stop();

    // R8 single entry with odd channel is exempt
    put(0, 8'h73);
    chk("R8 single", list_error, 0);
    start();
    conv(6, 100);
    chk("R2 unipolar", out_unipolar, 1);
    stop();
    chk("R11 stop", out_valid, 0);

    // R3 length 3 is odd -> error; R9 start refused
    put(1, 8'h01); put(2, 8'h02);
    hw(2'd2, 8'd2);
    chk("R8 odd len", list_error, 1);
    start();
    chk("R9 refused", out_valid, 0);
    hw(2'd3, 8'd0);
    chk("R3 sel3 noop", list_error, 1);

    // R7 parity break at slot 2, then fixed; slots beyond length ignored
    hw(2'd2, 8'd3);
    put(0, 8'h10); put(3, 8'h23); put(2, 8'h35);
    chk("R7 parity", list_error, 1);
    put(2, 8'h34);
    put(9, 8'h04);
    chk("R7 out of list", list_error, 0);

    // R6 start at slot 0, stall and R10 writes ignored while running
    start();
    chk("R6 start index", out_index, 0);
    conv(3, 100);
    hw(2'd1, 8'hF1);
    hw(2'd2, 8'd4);
    chk("R10 len kept", list_error, 0);
    conv(5, 0);
    acq_start = 1; conv_ready = 1; tick(); acq_start = 0; conv_ready = 0;
    stop();
    start();
    chk("R6 restart", out_index, 0);
    chk("R10 entry kept", out_chan, 0);
    acq_start = 1; acq_stop = 1; tick(); acq_start = 0; acq_stop = 0;
    chk("R11 stop wins", out_valid, 0);

    // R3 full 256-entry list
    for (int i = 0; i < 256; i++) put(i, legal_byte(i));
    hw(2'd2, 8'd255);
    chk("R3 full", list_error, 0);
    start();
    conv(600, 80);
    stop();

    // constrained random legal and illegal lists
    for (int it = 0; it < 30; it++) begin
      int len;
      len = 2 * (1 + $urandom % 20);
      if (it % 5 == 4) len = len + 1;
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = legal_byte(i);
        if (it % 7 == 6 && i == len / 2) b[0] = ~b[0];
        put(i, b);
      end
      hw(2'd2, 8'(len - 1));
      start();
      conv(20 + $urandom % 60, 30 + $urandom % 70);
      stop();
    end
    summary();
  end
endmodule